// File: doc/BRIEF.md
# Speculative Memory Access Filter

This block sits between a load/store unit and two memory targets: the architectural memory port and a speculative store buffer. It routes each request according to the execution mode that is current when the request is accepted. On the correct path every request goes unchanged to the architectural port. On a wrong path, ordinary loads and stores are redirected to the speculative buffer. Accesses that would have side effects are not issued at all, and they complete locally with fixed values, so wrong-path execution stays deterministic and leaves memory untouched.

Side-effect accesses are those marked uncacheable or locked, and system-call requests. The filter has one request in flight at a time. Both downstream ports use a valid/ready handshake for requests. Each downstream port returns its response as a single-cycle valid pulse. The block returns its own response to the load/store unit as a single-cycle `rsp_valid` pulse.

Top module: `spec_mem_filter`

## Requirements
- R1: When the mode sampled at acceptance is correct-path (`mis_mode`=0), reads and writes appear on the architectural port with address, write data, write flag, uncacheable flag and locked flag unchanged. The architectural response data, fault and result are returned unchanged.
- R2: A wrong-path read flagged uncacheable or locked is not presented on either downstream port. It completes one cycle after acceptance with data 0 and fault code 0, where 0 means no fault.
- R3: A wrong-path write flagged uncacheable or locked is dropped without touching either downstream port. It completes one cycle after acceptance with result 0 and fault 0.
- R4: Other wrong-path reads and writes go to the speculative port with address, write data and write flag unchanged. When the speculative fault is 0, its data and result are returned as given.
- R5: When the speculative port answers with a nonzero fault code, the response data is forced to 0 and the fault code is passed back unchanged.
- R6: A system-call request is forwarded to the architectural port with its system-call flag set when the mode is correct-path. In wrong-path mode it is dropped and completes one cycle after acceptance with data, result and fault all 0.
- R7: The mode is sampled when the request is accepted. A later change of `mis_mode` does not change the route or the response of that request.
- R8: Only one request is outstanding at a time. `req_ready` stays low from acceptance until the response cycle. At most one downstream request valid is high at a time. A downstream request stays valid with stable fields while its ready is low.
- R9: After reset `req_ready` is 1 and `rsp_valid`, `arch_req_valid` and `spec_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mis_mode | input | 1 | 1 while the core executes down a wrong path |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_uncache | input | 1 | Uncacheable attribute |
| req_locked | input | 1 | Locked attribute |
| req_syscall | input | 1 | System-call request |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Read data |
| rsp_fault | output | FW | Fault code, 0 = none |
| rsp_result | output | RW | Write result |
| arch_req_valid | output | 1 | Architectural request valid |
| arch_req_ready | input | 1 | Architectural port accepts |
| arch_addr | output | AW | Architectural address |
| arch_wdata | output | DW | Architectural store data |
| arch_write | output | 1 | Architectural write flag |
| arch_uncache | output | 1 | Architectural uncacheable flag |
| arch_locked | output | 1 | Architectural locked flag |
| arch_syscall | output | 1 | Architectural system-call flag |
| arch_rsp_valid | input | 1 | Architectural response pulse |
| arch_rdata | input | DW | Architectural read data |
| arch_fault | input | FW | Architectural fault code |
| arch_result | input | RW | Architectural write result |
| spec_req_valid | output | 1 | Speculative request valid |
| spec_req_ready | input | 1 | Speculative port accepts |
| spec_addr | output | AW | Speculative address |
| spec_wdata | output | DW | Speculative store data |
| spec_write | output | 1 | Speculative write flag |
| spec_rsp_valid | input | 1 | Speculative response pulse |
| spec_rdata | input | DW | Speculative read data |
| spec_fault | input | FW | Speculative fault code |
| spec_result | input | RW | Speculative write result |

## Verification
Reads and writes are issued in both modes, with each attribute (uncacheable, locked, system call) set alone. The port that carries each request separates the correct-path, buffered and suppressed routes. Distinct data patterns on the two downstream ports show which source a response came from. A nonzero fault on both ports shows that data is zeroed only on the speculative path. `mis_mode` is inverted right after every acceptance, which separates mode sampling at acceptance from live use of the mode. Held-off ready on each port checks that request fields stay stable under backpressure.

// File: rtl/spec_mem_filter.sv
module spec_mem_filter #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int FW = 4,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mis_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_uncache,
  input  logic          req_locked,
  input  logic          req_syscall,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [FW-1:0] rsp_fault,
  output logic [RW-1:0] rsp_result,
  output logic          arch_req_valid,
  input  logic          arch_req_ready,
  output logic [AW-1:0] arch_addr,
  output logic [DW-1:0] arch_wdata,
  output logic          arch_write,
  output logic          arch_uncache,
  output logic          arch_locked,
  output logic          arch_syscall,
  input  logic          arch_rsp_valid,
  input  logic [DW-1:0] arch_rdata,
  input  logic [FW-1:0] arch_fault,
  input  logic [RW-1:0] arch_result,
  output logic          spec_req_valid,
  input  logic          spec_req_ready,
  output logic [AW-1:0] spec_addr,
  output logic [DW-1:0] spec_wdata,
  output logic          spec_write,
  input  logic          spec_rsp_valid,
  input  logic [DW-1:0] spec_rdata,
  input  logic [FW-1:0] spec_fault,
  input  logic [RW-1:0] spec_result
);

  typedef enum logic [2:0] {
    S_IDLE, S_ARCH_REQ, S_ARCH_WAIT, S_SPEC_REQ, S_SPEC_WAIT
  } state_t;

  state_t        st;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;
  logic          h_write, h_uncache, h_locked, h_syscall;

  logic accept, side_effect;

  assign req_ready   = (st == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign side_effect = req_uncache || req_locked || req_syscall;

  assign arch_req_valid = (st == S_ARCH_REQ);
  assign arch_addr      = h_addr;
  assign arch_wdata     = h_wdata;
  assign arch_write     = h_write;
  assign arch_uncache   = h_uncache;
  assign arch_locked    = h_locked;
  assign arch_syscall   = h_syscall;

  assign spec_req_valid = (st == S_SPEC_REQ);
  assign spec_addr      = h_addr;
  assign spec_wdata     = h_wdata;
  assign spec_write     = h_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      h_addr     <= '0;
      h_wdata    <= '0;
      h_write    <= 1'b0;
      h_uncache  <= 1'b0;
      h_locked   <= 1'b0;
      h_syscall  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_fault  <= '0;
      rsp_result <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          h_addr    <= req_addr;
          h_wdata   <= req_wdata;
          h_write   <= req_write;
          h_uncache <= req_uncache;
          h_locked  <= req_locked;
          h_syscall <= req_syscall;
          if (!mis_mode) begin
            st <= S_ARCH_REQ;
          end else if (side_effect) begin
            rsp_valid  <= 1'b1;
            rsp_rdata  <= '0;
            rsp_fault  <= '0;
            rsp_result <= '0;
          end else begin
            st <= S_SPEC_REQ;
          end
        end
        S_ARCH_REQ: if (arch_req_ready) st <= S_ARCH_WAIT;
        S_ARCH_WAIT: if (arch_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_rdata  <= arch_rdata;
          rsp_fault  <= arch_fault;
          rsp_result <= arch_result;
          st         <= S_IDLE;
        end
        S_SPEC_REQ: if (spec_req_ready) st <= S_SPEC_WAIT;
        S_SPEC_WAIT: if (spec_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_rdata  <= (spec_fault != '0) ? '0 : spec_rdata;
          rsp_fault  <= spec_fault;
          rsp_result <= spec_result;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spec_mem_filter_chk.sv
module spec_mem_filter_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int FW = 4,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mis_mode,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          req_uncache,
  input logic          req_locked,
  input logic          req_syscall,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic [FW-1:0] rsp_fault,
  input logic [RW-1:0] rsp_result,
  input logic          arch_req_valid,
  input logic          arch_req_ready,
  input logic [AW-1:0] arch_addr,
  input logic          spec_req_valid,
  input logic          spec_req_ready,
  input logic [AW-1:0] spec_addr,
  input logic          spec_rsp_valid,
  input logic [FW-1:0] spec_fault
);

  logic acc;
  assign acc = req_valid && req_ready;

  assert_mutex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(arch_req_valid && spec_req_valid));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!arch_req_valid && !spec_req_valid));

  assert_arch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arch_req_valid && !arch_req_ready |=> arch_req_valid && $stable(arch_addr));

  assert_spec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spec_req_valid && !spec_req_ready |=> spec_req_valid && $stable(spec_addr));

  assert_route_arch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mis_mode |=> arch_req_valid);

  assert_route_spec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mis_mode && !(req_uncache || req_locked || req_syscall) |=> spec_req_valid);

  assert_supp_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mis_mode && !req_write && (req_uncache || req_locked) |=>
      rsp_valid && rsp_rdata == '0 && rsp_fault == '0 && !arch_req_valid && !spec_req_valid);

  assert_supp_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mis_mode && req_write && (req_uncache || req_locked) |=>
      rsp_valid && rsp_result == '0 && rsp_fault == '0 && !arch_req_valid && !spec_req_valid);

  assert_sys_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mis_mode && req_syscall |=> rsp_valid && !arch_req_valid && !spec_req_valid);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spec_rsp_valid && spec_fault != '0 && !req_ready && !spec_req_valid && !arch_req_valid |=>
      rsp_valid && rsp_rdata == '0 && rsp_fault == $past(spec_fault));

endmodule

bind spec_mem_filter spec_mem_filter_chk #(.AW(AW), .DW(DW), .FW(FW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mis_mode(mis_mode),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_uncache(req_uncache), .req_locked(req_locked), .req_syscall(req_syscall),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .rsp_result(rsp_result),
  .arch_req_valid(arch_req_valid), .arch_req_ready(arch_req_ready), .arch_addr(arch_addr),
  .spec_req_valid(spec_req_valid), .spec_req_ready(spec_req_ready), .spec_addr(spec_addr),
  .spec_rsp_valid(spec_rsp_valid), .spec_fault(spec_fault)
);

// File: tb/spec_mem_filter_tb.sv
`timescale 1ns/1ps
module spec_mem_filter_tb;
  localparam int AW = 32, DW = 64, FW = 4, RW = 8;

  logic clk = 0, rst_n = 0, mis_mode = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_write = 0, req_uncache = 0, req_locked = 0, req_syscall = 0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [FW-1:0] rsp_fault;
  logic [RW-1:0] rsp_result;
  logic arch_req_valid, arch_req_ready = 0;
  logic [AW-1:0] arch_addr;
  logic [DW-1:0] arch_wdata;
  logic arch_write, arch_uncache, arch_locked, arch_syscall;
  logic arch_rsp_valid = 0;
  logic [DW-1:0] arch_rdata = '0;
  logic [FW-1:0] arch_fault = '0;
  logic [RW-1:0] arch_result = '0;
  logic spec_req_valid, spec_req_ready = 0;
  logic [AW-1:0] spec_addr;
  logic [DW-1:0] spec_wdata;
  logic spec_write;
  logic spec_rsp_valid = 0;
  logic [DW-1:0] spec_rdata = '0;
  logic [FW-1:0] spec_fault = '0;
  logic [RW-1:0] spec_result = '0;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spec_mem_filter #(.AW(AW), .DW(DW), .FW(FW), .RW(RW)) u_dut (.*);

  // observations of the last transaction
  logic hit_arch, hit_spec, sys_seen, uc_seen, lk_seen, wr_seen;
  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_wdata, got_data;
  logic [FW-1:0] got_fault;
  logic [RW-1:0] got_result;
  int cycles;
  logic addr_moved;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [DW-1:0] ARCH_TAG = 64'hA5A5_0000_0000_0000;
  localparam logic [DW-1:0] SPEC_TAG = 64'h5A5A_0000_0000_0000;

  task automatic xact(input logic mode, input logic w, input logic uc, input logic lk,
                      input logic sc, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [FW-1:0] flt, input logic [RW-1:0] res, input int stall);
    int left;
    logic pa, ps, done;
    left = stall; pa = 0; ps = 0; done = 0;
    hit_arch = 0; hit_spec = 0; sys_seen = 0; uc_seen = 0; lk_seen = 0; wr_seen = 0;
    seen_addr = '0; seen_wdata = '0; cycles = 0; addr_moved = 0;
    @(negedge clk);
    mis_mode = mode; req_valid = 1; req_write = w; req_uncache = uc;
    req_locked = lk; req_syscall = sc; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; mis_mode = ~mode; req_uncache = 0; req_locked = 0; req_syscall = 0;
    req_addr = '1;
    for (int i = 0; i < 40 && !done; i++) begin
      cycles++;
      arch_rsp_valid = 0; spec_rsp_valid = 0; arch_req_ready = 0; spec_req_ready = 0;
      if (rsp_valid) begin
        got_data = rsp_rdata; got_fault = rsp_fault; got_result = rsp_result; done = 1;
      end else if (arch_req_valid) begin
        if (hit_arch && arch_addr != seen_addr) addr_moved = 1;
        hit_arch = 1; seen_addr = arch_addr; seen_wdata = arch_wdata;
        sys_seen = arch_syscall; uc_seen = arch_uncache; lk_seen = arch_locked; wr_seen = arch_write;
        if (left > 0) left--; else begin arch_req_ready = 1; pa = 1; end
      end else if (spec_req_valid) begin
        if (hit_spec && spec_addr != seen_addr) addr_moved = 1;
        hit_spec = 1; seen_addr = spec_addr; seen_wdata = spec_wdata; wr_seen = spec_write;
        if (left > 0) left--; else begin spec_req_ready = 1; ps = 1; end
      end else if (pa) begin
        pa = 0; arch_rsp_valid = 1; arch_rdata = ARCH_TAG | 64'(seen_addr);
        arch_fault = flt; arch_result = res;
      end else if (ps) begin
        ps = 0; spec_rsp_valid = 1; spec_rdata = SPEC_TAG | 64'(seen_addr);
        spec_fault = flt; spec_result = res;
      end
      if (!done) @(negedge clk);
    end
    if (!done) chk("no response", 0, 1);
  endtask

  task automatic t_reset;
    chk("R9 req_ready", req_ready, 1);
    chk("R9 rsp_valid", rsp_valid, 0);
    chk("R9 arch_req_valid", arch_req_valid, 0);
    chk("R9 spec_req_valid", spec_req_valid, 0);
  endtask

  task automatic t_arch;
    xact(0, 0, 1, 0, 0, 32'h100, '0, 4'h3, 8'h00, 0);
    chk("R1 read on arch", {hit_arch, hit_spec}, 2'b10);
    chk("R1 addr", seen_addr, 32'h100);
    chk("R1 uncache flag", uc_seen, 1);
    chk("R1 data", got_data, ARCH_TAG | 64'h100);
    chk("R1 fault passed", got_fault, 4'h3);
    xact(0, 1, 0, 1, 0, 32'h204, 64'hDEAD_BEEF_0011_2233, 4'h0, 8'h01, 0);
    chk("R1 write on arch", {hit_arch, hit_spec, wr_seen, lk_seen}, 4'b1011);
    chk("R1 wdata", seen_wdata, 64'hDEAD_BEEF_0011_2233);
    chk("R1 result", got_result, 8'h01);
  endtask

  task automatic t_supp_read;
    xact(1, 0, 1, 0, 0, 32'h300, '0, 4'h7, 8'h55, 0);
    chk("R2 uncache read untouched", {hit_arch, hit_spec}, 2'b00);
    chk("R2 data zero", got_data, 0);
    chk("R2 fault zero", got_fault, 0);
    chk("R2 latency", cycles, 1);
    xact(1, 0, 0, 1, 0, 32'h304, '0, 4'h7, 8'h55, 0);
    chk("R2 locked read untouched", {hit_arch, hit_spec, got_data == 0}, 3'b001);
  endtask

  task automatic t_supp_write;
    xact(1, 1, 0, 1, 0, 32'h400, 64'h1234, 4'h7, 8'h55, 0);
    chk("R3 locked write dropped", {hit_arch, hit_spec}, 2'b00);
    chk("R3 result zero", got_result, 0);
    chk("R3 fault zero", got_fault, 0);
    chk("R3 latency", cycles, 1);
    xact(1, 1, 1, 0, 0, 32'h404, 64'h1234, 4'h7, 8'h55, 0);
    chk("R3 uncache write dropped", {hit_arch, hit_spec, got_result == 0}, 3'b001);
  endtask

  task automatic t_spec;
    xact(1, 0, 0, 0, 0, 32'h500, '0, 4'h0, 8'h00, 0);
    chk("R4 read on spec", {hit_arch, hit_spec}, 2'b01);
    chk("R4 spec data", got_data, SPEC_TAG | 64'h500);
    xact(1, 1, 0, 0, 0, 32'h508, 64'hCAFE_0000_F00D_0001, 4'h0, 8'h9C, 0);
    chk("R4 write on spec", {hit_arch, hit_spec, wr_seen}, 3'b011);
    chk("R4 spec wdata", seen_wdata, 64'hCAFE_0000_F00D_0001);
    chk("R4 spec result", got_result, 8'h9C);
  endtask

  task automatic t_fault;
    xact(1, 0, 0, 0, 0, 32'h600, '0, 4'h5, 8'h00, 0);
    chk("R5 spec fault data zero", got_data, 0);
    chk("R5 spec fault code", got_fault, 4'h5);
  endtask

  task automatic t_sys;
    xact(0, 0, 0, 0, 1, 32'h700, '0, 4'h0, 8'h11, 0);
    chk("R6 syscall forwarded", {hit_arch, hit_spec, sys_seen}, 3'b101);
    xact(1, 0, 0, 0, 1, 32'h704, '0, 4'h2, 8'h11, 0);
    chk("R6 syscall dropped", {hit_arch, hit_spec}, 2'b00);
    chk("R6 zero response", {got_data, got_fault, got_result}, '0);
  endtask

  task automatic t_stall;
    xact(0, 0, 0, 0, 0, 32'h800, '0, 4'h0, 8'h00, 3);
    chk("R8 arch stall held", {hit_arch, addr_moved}, 2'b10);
    chk("R8 arch stall data", got_data, ARCH_TAG | 64'h800);
    xact(1, 1, 0, 0, 0, 32'h900, 64'h77, 4'h0, 8'h42, 4);
    chk("R8 spec stall held", {hit_spec, addr_moved}, 2'b10);
    chk("R8 spec stall result", got_result, 8'h42);
  endtask

  task automatic t_busy;
    @(negedge clk);
    mis_mode = 0; req_valid = 1; req_write = 0; req_addr = 32'hA00;
    @(negedge clk);
    req_valid = 0;
    chk("R8 ready low while outstanding", req_ready, 0);
    mis_mode = 1;
    @(negedge clk);
    chk("R7 route held after mode flip", {arch_req_valid, spec_req_valid}, 2'b10);
    arch_req_ready = 1;
    @(negedge clk);
    arch_req_ready = 0;
    chk("R8 ready low while waiting", req_ready, 0);
    arch_rsp_valid = 1; arch_rdata = 64'h1; arch_fault = 0; arch_result = 0;
    @(negedge clk);
    arch_rsp_valid = 0;
    chk("R7 response from arch", {rsp_valid, rsp_rdata}, {1'b1, 64'h1});
    chk("R8 ready back", req_ready, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_arch();
    t_supp_read();
    t_supp_write();
    t_spec();
    t_fault();
    t_sys();
    t_stall();
    t_busy();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule